// File: doc/BRIEF.md
# Lockstep Valid-Tagged Three-Stage Pipeline

This block runs a word through three fixed arithmetic stages: an add, an exclusive-or and a left rotation. There are two registers between the stages, and each register carries a valid flag. All stages move forward together on one advance condition.

The pipeline advances whenever the consumer can take a word, or whenever the tail register is empty. When no input is offered on an advance, an empty slot (a bubble) enters the first register and travels down the pipe like a word would. Slots that are not valid are never presented at the output. When the tail holds a real word and the consumer refuses it, the whole pipe freezes.

Both ends are valid/ready streams. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. It leaves on an edge where `out_valid` and `out_ready` are both high.

Top module: `lockstep_pipe`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied and right after it, `out_valid` is 0 and `in_ready` is 1. Both valid flags clear; the data registers keep whatever they hold.
- R2: In every cycle, `in_ready` equals `out_ready OR NOT out_valid`. This one advance term moves every stage.
- R3: On an advance with `in_valid` high, the input word is consumed and the first register becomes valid.
- R4: On an advance with `in_valid` low, the first register becomes a bubble. A bubble never raises `out_valid`.
- R5: On every advance, the second register takes the first register's contents and valid flag. A word accepted in cycle n is therefore presented at the output in cycle n+2 if both intervening edges advance.
- R6: `out_data` equals rotl(((x + K0) mod 2^W) XOR K1, ROT2). Defaults are W=16, K0=0x0013, K1=0x5A5A, ROT2=3.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. `out_valid` and `out_data` hold, and an offered input is ignored.
- R8: Every accepted word leaves exactly once, in acceptance order. No other word leaves.
- R9: While the tail is empty, the pipe keeps advancing and accepting input even with `out_ready` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Pipeline advances and takes the word |
| in_data | input | W | Input word |
| out_valid | output | 1 | Tail holds a real word |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | W | Result of the three stages |

## Verification
Acceptance of a new word and emission of a finished word can happen in the same cycle. Both depend on the same advance term. The bench provokes this with random input gaps and random consumer back-pressure, and also with a directed stall that fills the tail while a word is offered. Each cycle it judges the pair against a reference queue: `in_ready` must match the formula in R2, every emitted word must equal the queue head, and an input offered during a stall must never enter the queue or appear at the output.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_XOR  = 2'd1,
    OP_ROTL = 2'd2
  } op_kind_e;
endpackage

// File: rtl/lsp_op.sv
module lsp_op
  import lsp_pkg::*;
#(
  parameter int       W    = 16,
  parameter op_kind_e KIND = OP_ADD,
  parameter logic [W-1:0] ARG = '0
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam int SH = int'(ARG) % W;

  function automatic logic [W-1:0] f_add(input logic [W-1:0] a);
    return a + ARG;
  endfunction

  function automatic logic [W-1:0] f_xor(input logic [W-1:0] a);
    return a ^ ARG;
  endfunction

  function automatic logic [W-1:0] f_rotl(input logic [W-1:0] a);
    if (SH == 0) return a;
    return (a << SH) | (a >> (W - SH));
  endfunction

  generate
    case (KIND)
      OP_ADD:  begin : g_add  assign y = f_add(x);  end
      OP_XOR:  begin : g_xor  assign y = f_xor(x);  end
      default: begin : g_rotl assign y = f_rotl(x); end
    endcase
  endgenerate
endmodule

// File: rtl/lsp_slot.sv
module lsp_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         we_data,
  input  logic [W-1:0] nxt_data,
  input  logic         nxt_valid,
  output logic [W-1:0] q_data,
  output logic         q_valid
);
  // valid flag: reset, updated on every advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_valid <= 1'b0;
    else if (adv) q_valid <= nxt_valid;
  end

  // payload: no reset, written only when advancing with real data
  always_ff @(posedge clk) begin
    if (adv && we_data) q_data <= nxt_data;
  end
endmodule

// File: rtl/lsp_ctrl.sv
module lsp_ctrl (
  input  logic in_valid,
  input  logic out_ready,
  input  logic tail_valid,
  output logic adv,
  output logic take
);
  // single lockstep condition: consumer accepts, or tail slot is a bubble
  assign adv  = out_ready || !tail_valid;
  assign take = adv && in_valid;
endmodule

// File: rtl/lockstep_pipe.sv
module lockstep_pipe
  import lsp_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] K0 = W'(19),
  parameter logic [W-1:0] K1 = W'(23130),
  parameter int unsigned  ROT2 = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         adv_w, take_w;
  logic [W-1:0] s0_res, s1_res, s2_res;
  logic [W-1:0] r1_data, r2_data;
  logic         r1_valid, r2_valid;

  lsp_ctrl u_ctrl (
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .tail_valid(r2_valid),
    .adv       (adv_w),
    .take      (take_w)
  );

  lsp_op #(.W(W), .KIND(OP_ADD), .ARG(K0)) u_op0 (.x(in_data), .y(s0_res));

  lsp_slot #(.W(W)) u_r1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv_w),
    .we_data  (take_w),
    .nxt_data (s0_res),
    .nxt_valid(take_w),
    .q_data   (r1_data),
    .q_valid  (r1_valid)
  );

  lsp_op #(.W(W), .KIND(OP_XOR), .ARG(K1)) u_op1 (.x(r1_data), .y(s1_res));

  lsp_slot #(.W(W)) u_r2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv_w),
    .we_data  (r1_valid),
    .nxt_data (s1_res),
    .nxt_valid(r1_valid),
    .q_data   (r2_data),
    .q_valid  (r2_valid)
  );

  lsp_op #(.W(W), .KIND(OP_ROTL), .ARG(W'(ROT2))) u_op2 (.x(r2_data), .y(s2_res));

  assign in_ready  = adv_w;
  assign out_valid = r2_valid;
  assign out_data  = s2_res;

  // R1: reset leaves no word at the output
  p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R3: an accepted word fills the first register
  p_accept_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> r1_valid);

  // R4: advancing without input inserts a bubble
  p_bubble_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> !r1_valid);

  // R5: validity shifts from first to second register on advance
  p_valid_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> r2_valid == $past(r1_valid));

  // R7: a refused tail word freezes the pipe
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_stall_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(r1_valid) && $stable(r2_valid));

  // R9: an empty tail never blocks the input
  p_empty_tail_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !r2_valid |-> in_ready);
endmodule

// File: tb/lockstep_pipe_tb_top.sv
module lockstep_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] refq[$];
  bit stall_prev = 1'b0;
  logic [15:0] stall_data = '0;

  // {in_valid, out_ready, in_data}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 16'h0000}, {1'b1, 1'b1, 16'hFFFF}, {1'b0, 1'b1, 16'h1111},
    {1'b1, 1'b0, 16'h1234}, {1'b1, 1'b0, 16'h4321}, {1'b1, 1'b0, 16'hBEEF},
    {1'b0, 1'b1, 16'h0000}, {1'b1, 1'b1, 16'hA5A5}, {1'b1, 1'b1, 16'h5A5A},
    {1'b1, 1'b0, 16'h00FF}, {1'b0, 1'b0, 16'h0F0F}, {1'b1, 1'b1, 16'hFFED},
    {1'b0, 1'b1, 16'h0000}, {1'b0, 1'b1, 16'h0000}, {1'b1, 1'b0, 16'h8000},
    {1'b1, 1'b1, 16'h7FFF}, {1'b0, 1'b0, 16'h0001}, {1'b1, 1'b1, 16'h0002},
    {1'b1, 1'b1, 16'hC0DE}, {1'b0, 1'b1, 16'h0000}
  };

  lockstep_pipe dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] model(input logic [15:0] x);
    logic [15:0] a, b;
    a = x + 16'h0013;
    b = a ^ 16'h5A5A;
    return {b[12:0], b[15:13]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit iv, input bit ordy, input logic [15:0] d);
    logic [15:0] e;
    @(negedge clk);
    in_valid = iv; out_ready = ordy; in_data = d;
    #1;
    if (stall_prev)
      chk(out_valid && out_data == stall_data, "R7", "held word",
          {15'd0, out_valid, out_data}, {16'd1, stall_data});
    chk(in_ready == (ordy || !out_valid), "R2", "in_ready",
        {31'd0, in_ready}, {31'd0, (ordy || !out_valid)});
    if (out_valid && ordy) begin
      if (refq.size() == 0) chk(1'b0, "R8", "unexpected word", {16'd0, out_data}, 32'd0);
      else begin
        e = refq.pop_front();
        chk(out_data == e, "R6", "out_data", {16'd0, out_data}, {16'd0, e});
      end
    end
    if (iv && in_ready) refq.push_back(model(d));
    stall_prev = out_valid && !ordy;
    stall_data = out_data;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 16'h0);
    chk(refq.size() == 0, "R8", "words left", refq.size(), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready, "R1", "in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) step(VEC[i][17], VEC[i][16], VEC[i][15:0]);
    drain();

    // R3 R4 R5: single word latency with bubbles around it
    step(1'b1, 1'b1, 16'h2468);
    chk(!out_valid, "R4", "empty tail", {31'd0, out_valid}, 32'd0);
    step(1'b0, 1'b1, 16'h0);
    chk(!out_valid, "R4", "bubble at n+1", {31'd0, out_valid}, 32'd0);
    step(1'b0, 1'b1, 16'h0);
    chk(out_valid && out_data == model(16'h2468), "R5", "word at n+2",
        {15'd0, out_valid, out_data}, {16'd1, model(16'h2468)});
    chk(out_valid, "R3", "accepted word emerged", {31'd0, out_valid}, 32'd1);
    step(1'b0, 1'b1, 16'h0);
    chk(!out_valid, "R4", "bubble after word", {31'd0, out_valid}, 32'd0);

    // R9 R7: back-pressure into an empty pipe, then stall ignores input
    step(1'b1, 1'b0, 16'h1357);
    chk(in_ready, "R9", "accept with empty tail", {31'd0, in_ready}, 32'd1);
    step(1'b0, 1'b0, 16'h0);
    chk(in_ready, "R9", "advance with empty tail", {31'd0, in_ready}, 32'd1);
    step(1'b0, 1'b0, 16'h0);
    chk(out_valid && !in_ready, "R7", "stalled", {30'd0, out_valid, in_ready}, 32'd2);
    step(1'b1, 1'b0, 16'h9999);
    chk(!in_ready, "R7", "input ignored", {31'd0, in_ready}, 32'd0);
    drain();

    // R1: reset in the middle of traffic
    step(1'b1, 1'b0, 16'h0101);
    step(1'b1, 1'b0, 16'h0202);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    chk(!out_valid && in_ready, "R1", "mid-run reset", {30'd0, out_valid, in_ready}, 32'd1);
    refq.delete();
    stall_prev = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1, 16'h0);
    chk(!out_valid, "R1", "no word after reset", {31'd0, out_valid}, 32'd0);

    // R8: random gaps and back-pressure
    for (int i = 0; i < 800; i++)
      step(($urandom % 4) != 0, ($urandom % 3) != 0, 16'($urandom));
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule